// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Sequencer

This block is the digital half of a 10-bit charge-balance successive-approximation converter. A processor writes one control byte that names an input channel (0 to 14) and a sample-time code. That single write starts a conversion. The block selects the channel on the analog multiplexer and holds the sample-and-hold in its sampling phase for the programmed number of timebase ticks. It then walks a trial code down from the most significant bit. On each tick it keeps or drops the bit under test according to the comparator.

The sequencer moves only on a dedicated timebase enable (`tickEn`), so conversion time does not depend on how fast the processor clock runs. A module-enable input keeps the converter idle when it is low, and it aborts a conversion in progress. Software polls the end-of-conversion flag, or takes the one-cycle interrupt pulse. It then reads the upper eight result bits from one register, and the two low bits together with the flags from the status register.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, EOC reads 1, the result is 0, `holdCtl` is 0, `dacCode` is 0, `irqPulse` is 0 and `muxSel` is 0.
- R2: A write (`wrEn` high at a clock edge) with channel field `wrData[3:0]` below 15 is accepted when the block is enabled and idle. After that edge `muxSel` shows the channel and EOC reads 0.
- R3: A write is ignored when it carries channel code 15, arrives while EOC is 0, or arrives while `modEnable` is 0. `muxSel`, EOC and the conversion in progress are left unchanged.
- R4: Sample-time code `wrData[5:4]` values 0, 1, 2 and 3 hold `holdCtl` high for exactly 4, 8, 16 and 32 `tickEn` cycles. `holdCtl` rises after the accepting edge.
- R5: Sampling and bit trials advance only on edges where `tickEn` is high. Without ticks the block stays in its current phase indefinitely.
- R6: The trial phase begins with `dacCode` = 0x200. On each tick the bit under test is kept if `cmpIn` is 1 and cleared if it is 0. The next lower bit is then set. Bits are resolved from bit 9 down to bit 0, and `dacCode` reads 0 outside the trial phase.
- R7: On the tick that resolves bit 0, the 10-bit result is stored and EOC returns to 1. For an ideal comparator (input ≥ code), the result equals the input value.
- R8: `irqPulse` is high for exactly one cycle, in the cycle where EOC has just risen at the end of a completed conversion.
- R9: `resultHi` carries result bits 9:2. `statusReg` bit 7 is EOC, bit 6 is the raw `cmpIn`, bits 5:2 read 0, and bits 1:0 are result bits 1:0.
- R10: Dropping `modEnable` during a conversion aborts it at the next edge. EOC goes to 1, `holdCtl` and `dacCode` go to 0, the stored result is unchanged and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Timebase enable that paces sampling and trials |
| modEnable | input | 1 | Converter enable; low keeps it idle and aborts |
| wrEn | input | 1 | Control-register write strobe |
| wrData | input | 8 | Write data: [5:4] sample-time code, [3:0] channel |
| cmpIn | input | 1 | Comparator output, 1 when input ≥ trial code |
| muxSel | output | 4 | Analog multiplexer channel select |
| holdCtl | output | 1 | Sample-and-hold control, high while sampling |
| dacCode | output | 10 | Trial code to the capacitor DAC |
| irqPulse | output | 1 | One-cycle end-of-conversion interrupt |
| statusReg | output | 8 | EOC, raw comparator, result bits 1:0 |
| resultHi | output | 8 | Result bits 9:2 |

## Verification
A wrong phase counter shows up at once as `holdCtl` lasting a different number of ticks than the code asks for. A wrong bit index or keep/drop decision changes `dacCode` on the very next tick, well before the result is stored. The bench therefore compares every output against a behavioural model on every clock. A fault is reported in the cycle it first reaches a port, not at the end of the conversion. Ignored writes, missing ticks and aborts are checked through `muxSel`, EOC and the stored result, read back through the status and result registers.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  localparam int RES_W  = 10;
  localparam int CH_W   = 4;
  localparam int NUM_CH = 15;
  localparam int ST_W   = 2;
  localparam int REG_W  = 8;
  localparam int BIT_W  = $clog2(RES_W);

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_SAMPLE,
    SEQ_TRIAL
  } seqState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic             load;
    logic             sampling;
    logic             trialBegin;
    logic             stepBit;
    logic             finish;
    logic             abort;
    logic [BIT_W-1:0] bitIdx;
  } seqStrobe_t;
endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_adc_pkg::*;
#(
  parameter int BASE_TICKS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             modEnable,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output seqStrobe_t       strb,
  output logic             seqIdle
);
  localparam int MAX_TICKS = BASE_TICKS << ((1 << ST_W) - 1);
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  seqState_e        state;
  logic [CNT_W-1:0] sampleCnt;
  logic [BIT_W-1:0] bitIdx;
  logic [CH_W-1:0]  chField;
  logic [ST_W-1:0]  stField;
  logic             accept;

  assign chField = wrData[CH_W-1:0];
  assign stField = wrData[CH_W +: ST_W];
  assign accept  = wrEn && modEnable && (state == SEQ_IDLE) && (chField < CH_W'(NUM_CH));

  always_comb begin
    strb            = '0;
    strb.load       = accept;
    strb.sampling   = (state == SEQ_SAMPLE);
    strb.trialBegin = modEnable && tickEn && (state == SEQ_SAMPLE) && (sampleCnt == CNT_W'(1));
    strb.stepBit    = modEnable && tickEn && (state == SEQ_TRIAL);
    strb.finish     = strb.stepBit && (bitIdx == '0);
    strb.abort      = !modEnable && (state != SEQ_IDLE);
    strb.bitIdx     = bitIdx;
  end

  assign seqIdle = (state == SEQ_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= SEQ_IDLE;
      sampleCnt <= '0;
      bitIdx    <= '0;
    end else if (!modEnable) begin
      state <= SEQ_IDLE;
    end else begin
      unique case (state)
        SEQ_IDLE: if (accept) begin
          state     <= SEQ_SAMPLE;
          sampleCnt <= CNT_W'(BASE_TICKS) << stField;
        end
        SEQ_SAMPLE: if (tickEn) begin
          if (sampleCnt == CNT_W'(1)) begin
            state  <= SEQ_TRIAL;
            bitIdx <= BIT_W'(RES_W - 1);
          end else begin
            sampleCnt <= sampleCnt - 1'b1;
          end
        end
        SEQ_TRIAL: if (tickEn) begin
          if (bitIdx == '0) state <= SEQ_IDLE;
          else              bitIdx <= bitIdx - 1'b1;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R5: without a tick an active phase does not move
  p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state != SEQ_IDLE) && !tickEn && modEnable |=> $stable(state) && $stable(sampleCnt) && $stable(bitIdx));

  // R6: bits are resolved strictly downward
  p_bit_descend_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepBit && !strb.finish |=> bitIdx == $past(bitIdx) - 1'b1);
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_adc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic [REG_W-1:0] wrData,
  input  logic             cmpIn,
  output logic [CH_W-1:0]  muxSel,
  output logic [RES_W-1:0] dacCode,
  output logic [RES_W-1:0] result,
  output logic             eoc,
  output logic             irqPulse
);
  logic [RES_W-1:0] trialReg;
  logic [RES_W-1:0] nextTrial;

  always_comb begin
    nextTrial = trialReg;
    if (!cmpIn) nextTrial[strb.bitIdx] = 1'b0;
    if (!strb.finish) nextTrial[strb.bitIdx - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      muxSel   <= '0;
      trialReg <= '0;
      result   <= '0;
      eoc      <= 1'b1;
      irqPulse <= 1'b0;
    end else begin
      irqPulse <= 1'b0;
      if (strb.abort) begin
        trialReg <= '0;
        eoc      <= 1'b1;
      end else if (strb.load) begin
        muxSel <= wrData[CH_W-1:0];
        eoc    <= 1'b0;
      end else if (strb.trialBegin) begin
        trialReg <= RES_W'(1) << (RES_W - 1);
      end else if (strb.stepBit) begin
        if (strb.finish) begin
          result   <= nextTrial;
          trialReg <= '0;
          eoc      <= 1'b1;
          irqPulse <= 1'b1;
        end else begin
          trialReg <= nextTrial;
        end
      end
    end
  end

  assign dacCode = trialReg;

  // R8: the interrupt never lasts two cycles
  p_irq_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  // R8: the interrupt coincides with a fresh EOC rise
  p_irq_on_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> eoc && !$past(eoc));

  // R6: trials start at the MSB
  p_msb_first_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.trialBegin |=> dacCode == (RES_W'(1) << (RES_W - 1)));
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int BASE_TICKS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        modEnable,
  input  logic        wrEn,
  input  logic [7:0]  wrData,
  input  logic        cmpIn,
  output logic [3:0]  muxSel,
  output logic        holdCtl,
  output logic [9:0]  dacCode,
  output logic        irqPulse,
  output logic [7:0]  statusReg,
  output logic [7:0]  resultHi
);
  seqStrobe_t       strb;
  logic             seqIdle;
  logic             eoc;
  logic [RES_W-1:0] result;

  sar_seq_ctrl #(.BASE_TICKS(BASE_TICKS)) uCtrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .modEnable(modEnable),
    .wrEn(wrEn), .wrData(wrData), .strb(strb), .seqIdle(seqIdle)
  );

  sar_datapath uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .cmpIn(cmpIn),
    .muxSel(muxSel), .dacCode(dacCode), .result(result), .eoc(eoc),
    .irqPulse(irqPulse)
  );

  assign holdCtl   = strb.sampling;
  assign resultHi  = result[RES_W-1 -: REG_W];
  assign statusReg = {eoc, cmpIn, {(REG_W-4){1'b0}}, result[1:0]};

  // R7: EOC in the datapath tracks the sequencer being idle
  p_eoc_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    eoc == seqIdle);

  // R3: a write during a busy conversion leaves the channel alone
  p_busy_ignore_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !eoc |=> $stable(muxSel) && !eoc || !$past(modEnable));

  // R10: disable forces the idle outputs at the next edge
  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !modEnable |=> eoc && !holdCtl && dacCode == '0 && !irqPulse);
endmodule

// File: tb/sar_adc_ctrl_test.sv
module sar_adc_ctrl_test;
  localparam int PERIOD = 10;

  logic       clk = 0;
  logic       rstN = 0;
  logic       tickEn = 0;
  logic       modEnable = 0;
  logic       wrEn = 0;
  logic [7:0] wrData = 0;
  logic       cmpIn;
  logic [3:0] muxSel;
  logic       holdCtl;
  logic [9:0] dacCode;
  logic       irqPulse;
  logic [7:0] statusReg;
  logic [7:0] resultHi;

  int vin [16];
  int checks = 0, fails = 0;
  int tickDiv = 1, tickGate = 0, cyc = 0;
  int holdTicks = 0, irqCount = 0;
  bit cmpOn = 0;

  // reference model state
  int mSt = 0, mCnt = 0, mBit = 0, mCode = 0, mRes = 0, mCh = 0, mEoc = 1, mIrq = 0;

  always #(PERIOD/2) clk = ~clk;

  assign cmpIn = (vin[muxSel] >= int'(dacCode));

  sar_adc_ctrl uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .modEnable(modEnable),
    .wrEn(wrEn), .wrData(wrData), .cmpIn(cmpIn), .muxSel(muxSel),
    .holdCtl(holdCtl), .dacCode(dacCode), .irqPulse(irqPulse),
    .statusReg(statusReg), .resultHi(resultHi)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    mIrq = 0;
    if (!rstN) begin
      mSt = 0; mEoc = 1; mRes = 0; mCode = 0; mCh = 0; mCnt = 0; mBit = 0;
    end else if (!modEnable) begin
      if (mSt != 0) begin mSt = 0; mEoc = 1; mCode = 0; end
    end else begin
      case (mSt)
        0: if (wrEn && wrData[3:0] != 4'd15) begin
          mCh = wrData[3:0]; mCnt = 4 << wrData[5:4]; mSt = 1; mEoc = 0;
        end
        1: if (tickEn) begin
          if (mCnt == 1) begin mSt = 2; mCode = 512; mBit = 9; end
          else mCnt--;
        end
        2: if (tickEn) begin
          if (vin[mCh] < mCode) mCode &= ~(1 << mBit);
          if (mBit == 0) begin
            mRes = mCode; mEoc = 1; mIrq = 1; mSt = 0; mCode = 0;
          end else begin
            mBit--; mCode |= (1 << mBit);
          end
        end
        default: mSt = 0;
      endcase
    end
  end

  // per-cycle comparison, tick generation and event counting
  always @(negedge clk) begin
    int expDac, expCmp, expStat;
    cyc++;
    if (cmpOn) begin
      expDac  = (mSt == 2) ? mCode : 0;
      expCmp  = (vin[mCh] >= expDac) ? 1 : 0;
      expStat = (mEoc << 7) | (expCmp << 6) | (mRes & 3);
      check(int'(muxSel) == mCh, "R2 muxSel", muxSel, mCh);
      check(int'(holdCtl) == (mSt == 1 ? 1 : 0), "R4 holdCtl", holdCtl, mSt == 1);
      check(int'(dacCode) == expDac, "R6 dacCode", dacCode, expDac);
      check(int'(irqPulse) == mIrq, "R8 irqPulse", irqPulse, mIrq);
      check(int'(statusReg) == expStat, "R9 statusReg", statusReg, expStat);
      check(int'(resultHi) == ((mRes >> 2) & 255), "R7 resultHi", resultHi, (mRes >> 2) & 255);
    end
    tickEn = (tickGate == 0) && ((cyc % tickDiv) == 0);
    if (holdCtl && tickEn) holdTicks++;
    if (irqPulse) irqCount++;
  end

  task automatic doWrite(input int ch, input int code);
    @(negedge clk); #1;
    wrData = 8'((code << 4) | ch);
    wrEn = 1;
    @(negedge clk); #1;
    wrEn = 0;
  endtask

  task automatic waitEoc();
    int guard = 0;
    while (!statusReg[7] && guard < 5000) begin
      @(negedge clk); #1;
      guard++;
    end
  endtask

  task automatic runConv(input int ch, input int code, input int div);
    tickDiv = div;
    @(negedge clk); #1;
    holdTicks = 0; irqCount = 0;
    doWrite(ch, code);
    check(statusReg[7] == 1'b0, "R2 eoc cleared", statusReg[7], 0);
    waitEoc();
    repeat (2) @(negedge clk); #1;
    check({resultHi, statusReg[1:0]} == 10'(vin[ch]), "R7 result", {resultHi, statusReg[1:0]}, vin[ch]);
    check(holdTicks == (4 << code), "R4 sample ticks", holdTicks, 4 << code);
    check(irqCount == 1, "R8 irq count", irqCount, 1);
    check(int'(muxSel) == ch, "R2 channel", muxSel, ch);
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL R7 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) vin[i] = (i * 67 + 13) % 1024;
    vin[3] = 'h2A5; vin[7] = 1023; vin[0] = 0; vin[14] = 512; vin[15] = 0;
    repeat (3) @(negedge clk);
    #1;
    rstN = 1;
    cmpOn = 1;
    @(negedge clk); #1;
    // R1 reset state
    check(statusReg[7] == 1'b1, "R1 eoc", statusReg[7], 1);
    check(resultHi == 8'd0 && statusReg[1:0] == 2'd0, "R1 result", resultHi, 0);
    check(!holdCtl && dacCode == 10'd0 && !irqPulse && muxSel == 4'd0, "R1 outputs", dacCode, 0);

    // R3 write while disabled is ignored
    doWrite(5, 0);
    @(negedge clk); #1;
    check(statusReg[7] == 1'b1 && !holdCtl, "R3 disabled write", statusReg[7], 1);
    check(muxSel == 4'd0, "R3 disabled channel", muxSel, 0);

    modEnable = 1;
    runConv(3, 0, 1);
    runConv(7, 1, 3);
    runConv(0, 2, 1);
    runConv(14, 3, 2);

    // R3 channel 15 is ignored
    doWrite(15, 1);
    @(negedge clk); #1;
    check(statusReg[7] == 1'b1 && !holdCtl, "R3 channel 15", statusReg[7], 1);
    check(muxSel == 4'd14, "R3 channel 15 mux", muxSel, 14);

    // R3 write while busy is ignored
    tickDiv = 1;
    doWrite(2, 0);
    repeat (6) @(negedge clk); #1;
    doWrite(9, 3);
    check(muxSel == 4'd2 && statusReg[7] == 1'b0, "R3 busy write", muxSel, 2);
    waitEoc();
    @(negedge clk); #1;
    check({resultHi, statusReg[1:0]} == 10'(vin[2]), "R3 busy result", {resultHi, statusReg[1:0]}, vin[2]);

    // R5 no ticks, no progress
    tickGate = 1;
    doWrite(6, 0);
    repeat (20) @(negedge clk); #1;
    check(holdCtl == 1'b1 && statusReg[7] == 1'b0, "R5 stalled sample", holdCtl, 1);
    check(dacCode == 10'd0, "R5 stalled dac", dacCode, 0);
    tickGate = 0;
    waitEoc();
    @(negedge clk); #1;
    check({resultHi, statusReg[1:0]} == 10'(vin[6]), "R5 result", {resultHi, statusReg[1:0]}, vin[6]);

    // R10 abort by disable
    begin
      int prevHi, guard;
      prevHi = resultHi;
      irqCount = 0;
      doWrite(4, 0);
      guard = 0;
      while (dacCode == 10'd0 && guard < 200) begin @(negedge clk); #1; guard++; end
      repeat (2) @(negedge clk); #1;
      modEnable = 0;
      @(negedge clk); #1;
      check(statusReg[7] == 1'b1, "R10 eoc", statusReg[7], 1);
      check(!holdCtl && dacCode == 10'd0, "R10 idle outputs", dacCode, 0);
      check(int'(resultHi) == prevHi, "R10 result kept", resultHi, prevHi);
      repeat (3) @(negedge clk); #1;
      check(irqCount == 0, "R10 no irq", irqCount, 0);
      modEnable = 1;
    end

    runConv(4, 0, 1);
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule